// File: doc/BRIEF.md
# Banked Bitmap Video Scan-Out Controller

This block keeps a one-bit-per-pixel picture in twelve small memory banks, laid out as three bank rows of four banks each. It streams that picture out as serial video, one pixel per clock, left to right and top to bottom. Two strobes mark the start of each line and of each frame. The banks are treated as slow. Once per four pixels, all four banks of the active bank row are read in one access into one of two 4-bit holding latches. While that happens, the other latch is shifted out one pixel per clock. Screen column x lives in bank `x mod 4`, at bank column `x / 4`. Screen row y lives in bank row `y / BANK_H`, at bank row offset `y mod BANK_H`. A single free-running counter of column and row drives the whole scan.

Software changes the picture in two ways. It can post a single pixel write. The write waits until the scan reaches the nibble that holds the pixel, and it is then committed in place of that bank's read. It can also request a whole-screen clear. The clear turns every read of one complete frame into a write of a chosen fill value. The video stream never stalls for either. The default geometry uses 16x16 banks, giving a 64x48 raster. Setting `BANK_W = BANK_H = 64` gives the full 256x192 raster.

Top module: `vid_bitmap_scan`

## Requirements
- R1: `pix_o` carries exactly one pixel per clock. A frame is H = 4*BANK_W pixels per line and V = 3*BANK_H lines, in raster order. Each pixel shows the bit stored for its (x, y) position.
- R2: `hsync_o` is high for exactly one cycle, in the same cycle as the first pixel of every line, so it repeats every H cycles.
- R3: `vsync_o` is high for exactly one cycle, in the same cycle as pixel (0,0). It always coincides with `hsync_o` and repeats every H*V cycles.
- R4: A committed write of value v to (x, y) makes that pixel show v in every later frame and leaves every other pixel unchanged. This holds at bank edges and at screen corners.
- R5: A write accepted while no other write is pending is committed within H*V cycles. `wr_done_o` then pulses high for one cycle.
- R6: A write request made while an earlier write is still pending is dropped. It produces no `wr_done_o` and changes no pixel.
- R7: A write request with `wr_y_i >= V` is dropped. It produces no `wr_done_o`, changes no pixel, and does not block a later valid write.
- R8: After a clear request, the first frame that starts more than 8 cycles later shows the fill value in every pixel. That fill value is `clr_fill_i` sampled with `clr_req_i`, where 1 means lit. The fill stays stored afterwards.
- R9: A write that is pending while a clear is waiting or in progress is not committed during the cleared frame. It is committed in a later frame and shows on top of the fill.
- R10: While `rst_ni` is low, `pix_o`, `hsync_o`, `vsync_o` and `wr_done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_req_i | input | 1 | One-cycle pixel write request |
| wr_x_i | input | log2(4*BANK_W) | Write column |
| wr_y_i | input | clog2(3*BANK_H) | Write row |
| wr_val_i | input | 1 | Value to write, 1 = lit |
| wr_done_o | output | 1 | One-cycle pulse when the write is committed |
| clr_req_i | input | 1 | One-cycle whole-screen clear request |
| clr_fill_i | input | 1 | Fill value used by the clear |
| pix_o | output | 1 | Serial video pixel |
| hsync_o | output | 1 | Line-start strobe |
| vsync_o | output | 1 | Frame-start strobe |

## Verification
The bench checks whole frames pixel by pixel against an image it keeps itself. It also checks the sync strobes on every pixel of those frames. Suppose the latch parity, the bank interleave or the next-nibble address is wrong. Then a group of four pixels comes out swapped or stale, and this shows in the very next frame compared after the fault. A wrong slot match or pending flag shows up in a different way: `wr_done_o` arrives late, never arrives, or arrives twice, and the bench sees this within one frame time.

// File: rtl/vid_pkg.sv
package vid_pkg;
  localparam int NIB       = 4;  // banks per bank row = pixels per latch
  localparam int BANK_ROWS = 3;

  typedef enum logic [1:0] {
    SL_READ  = 2'd0,
    SL_PIXEL = 2'd1,
    SL_FILL  = 2'd2
  } slot_e;
endpackage

// File: rtl/vid_bank.sv
module vid_bank #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wd_i,
  output logic          rd_o
);
  localparam int DEPTH = 1 << AW;

  logic mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wd_i;
  end

  assign rd_o = mem_q[addr_i];
endmodule

// File: rtl/vid_scan_ctr.sv
module vid_scan_ctr #(
  parameter int XW = 6,
  parameter int YW = 6,
  parameter int V  = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          slot_o,
  output logic [XW-3:0] ncol_o,
  output logic [YW-1:0] ny_o,
  output logic          nfirst_o,
  output logic          nlast_o
);
  localparam logic [YW-1:0] YMAX = YW'(V - 1);

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [XW-3:0] col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_q + 1'b1;
      if (&x_q) y_q <= (y_q == YMAX) ? '0 : y_q + 1'b1;
    end
  end

  assign col = x_q[XW-1:2];

  // address of the nibble following the one being shown
  always_comb begin
    ncol_o = col + 1'b1;
    ny_o   = y_q;
    if (&col) ny_o = (y_q == YMAX) ? '0 : y_q + 1'b1;
  end

  assign x_o      = x_q;
  assign y_o      = y_q;
  assign slot_o   = (x_q[1:0] == 2'b00);
  assign nfirst_o = (ncol_o == '0) && (ny_o == '0);
  assign nlast_o  = (&ncol_o) && (ny_o == YMAX);
endmodule

// File: rtl/vid_req.sv
module vid_req
  import vid_pkg::*;
#(
  parameter int XW = 6,
  parameter int YW = 6,
  parameter int V  = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [XW-1:0] wr_x_i,
  input  logic [YW-1:0] wr_y_i,
  input  logic          wr_val_i,
  input  logic          clr_req_i,
  input  logic          clr_fill_i,
  input  logic          slot_i,
  input  logic [XW-3:0] ncol_i,
  input  logic [YW-1:0] ny_i,
  input  logic          nfirst_i,
  input  logic          nlast_i,
  output slot_e         kind_o,
  output logic [1:0]    hit_bank_o,
  output logic          wval_o,
  output logic          fill_o,
  output logic          clr_act_o,
  output logic          wr_pend_o,
  output logic          done_o
);
  logic          pend_q, done_q;
  logic [XW-1:0] wx_q;
  logic [YW-1:0] wy_q;
  logic          wv_q;
  logic          clr_pend_q, clr_act_q, fill_req_q, fill_act_q;
  logic          clr_start, fill_now, pix_hit, accept;

  assign accept    = wr_req_i && !pend_q && (int'(wr_y_i) < V);
  assign clr_start = slot_i && clr_pend_q && nfirst_i && !clr_act_q;
  assign fill_now  = slot_i && (clr_act_q || clr_start);
  // clear wins: pixel writes wait while a clear is queued or running
  assign pix_hit   = slot_i && pend_q && !clr_pend_q && !clr_act_q &&
                     (wy_q == ny_i) && (wx_q[XW-1:2] == ncol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      done_q     <= 1'b0;
      wx_q       <= '0;
      wy_q       <= '0;
      wv_q       <= 1'b0;
      clr_pend_q <= 1'b0;
      clr_act_q  <= 1'b0;
      fill_req_q <= 1'b0;
      fill_act_q <= 1'b0;
    end else begin
      done_q <= pix_hit;
      if (pix_hit) begin
        pend_q <= 1'b0;
      end else if (accept) begin
        pend_q <= 1'b1;
        wx_q   <= wr_x_i;
        wy_q   <= wr_y_i;
        wv_q   <= wr_val_i;
      end

      if (clr_start) begin
        clr_act_q  <= 1'b1;
        fill_act_q <= fill_req_q;
      end else if (clr_act_q && slot_i && nlast_i) begin
        clr_act_q <= 1'b0;
      end

      if (clr_req_i) begin
        clr_pend_q <= 1'b1;
        fill_req_q <= clr_fill_i;
      end else if (clr_start) begin
        clr_pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    kind_o = SL_READ;
    if (fill_now)     kind_o = SL_FILL;
    else if (pix_hit) kind_o = SL_PIXEL;
  end

  assign hit_bank_o = wx_q[1:0];
  assign wval_o     = wv_q;
  assign fill_o     = clr_act_q ? fill_act_q : fill_req_q;
  assign clr_act_o  = clr_act_q;
  assign wr_pend_o  = pend_q;
  assign done_o     = done_q;
endmodule

// File: rtl/vid_bitmap_scan.sv
module vid_bitmap_scan
  import vid_pkg::*;
#(
  parameter int BANK_W = 16,
  parameter int BANK_H = 16,
  localparam int H   = NIB * BANK_W,
  localparam int V   = BANK_ROWS * BANK_H,
  localparam int XW  = $clog2(H),
  localparam int YW  = $clog2(V)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [XW-1:0] wr_x_i,
  input  logic [YW-1:0] wr_y_i,
  input  logic          wr_val_i,
  output logic          wr_done_o,
  input  logic          clr_req_i,
  input  logic          clr_fill_i,
  output logic          pix_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  localparam int BCW = $clog2(BANK_W);
  localparam int BRW = $clog2(BANK_H);
  localparam int AW  = BCW + BRW;

  logic [XW-1:0]  x_w;
  logic [YW-1:0]  y_w;
  logic           slot_w, nfirst_w, nlast_w;
  logic [XW-3:0]  ncol_w;
  logic [YW-1:0]  ny_w;
  slot_e          kind_w;
  logic [1:0]     hit_bank_w;
  logic           wval_w, fill_w, clr_act_w, wr_pend_w;
  logic [YW-BRW-1:0] row_sel;
  logic [AW-1:0]  baddr;
  logic           rd_w [BANK_ROWS][NIB];
  logic [NIB-1:0] row_rd, load;
  logic [NIB-1:0] lat_q [2];
  logic           pix_q, hs_q, vs_q;

  vid_scan_ctr #(.XW(XW), .YW(YW), .V(V)) i_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .x_o      (x_w),
    .y_o      (y_w),
    .slot_o   (slot_w),
    .ncol_o   (ncol_w),
    .ny_o     (ny_w),
    .nfirst_o (nfirst_w),
    .nlast_o  (nlast_w)
  );

  vid_req #(.XW(XW), .YW(YW), .V(V)) i_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_req_i),
    .wr_x_i     (wr_x_i),
    .wr_y_i     (wr_y_i),
    .wr_val_i   (wr_val_i),
    .clr_req_i  (clr_req_i),
    .clr_fill_i (clr_fill_i),
    .slot_i     (slot_w),
    .ncol_i     (ncol_w),
    .ny_i       (ny_w),
    .nfirst_i   (nfirst_w),
    .nlast_i    (nlast_w),
    .kind_o     (kind_w),
    .hit_bank_o (hit_bank_w),
    .wval_o     (wval_w),
    .fill_o     (fill_w),
    .clr_act_o  (clr_act_w),
    .wr_pend_o  (wr_pend_w),
    .done_o     (wr_done_o)
  );

  assign row_sel = ny_w[YW-1:BRW];
  assign baddr   = {ny_w[BRW-1:0], ncol_w};

  for (genvar gr = 0; gr < BANK_ROWS; gr++) begin : g_row
    for (genvar gb = 0; gb < NIB; gb++) begin : g_bank
      logic we;
      assign we = slot_w && (int'(row_sel) == gr) &&
                  ((kind_w == SL_FILL) ||
                   ((kind_w == SL_PIXEL) && (int'(hit_bank_w) == gb)));
      vid_bank #(.AW(AW)) i_bank (
        .clk_i  (clk_i),
        .we_i   (we),
        .addr_i (baddr),
        .wd_i   ((kind_w == SL_FILL) ? fill_w : wval_w),
        .rd_o   (rd_w[gr][gb])
      );
    end
  end

  always_comb begin
    row_rd = '0;
    for (int r = 0; r < BANK_ROWS; r++) begin
      if (int'(row_sel) == r) begin
        for (int b = 0; b < NIB; b++) row_rd[b] = rd_w[r][b];
      end
    end
  end

  // write-through so the committed bit is shown in the same pass
  always_comb begin
    load = row_rd;
    case (kind_w)
      SL_FILL:  load = {NIB{fill_w}};
      SL_PIXEL: load[hit_bank_w] = wval_w;
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q[0] <= '0;
      lat_q[1] <= '0;
      pix_q    <= 1'b0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
    end else begin
      if (slot_w) lat_q[!x_w[2]] <= load;
      pix_q <= lat_q[x_w[2]][x_w[1:0]];
      hs_q  <= (x_w == '0);
      vs_q  <= (x_w == '0) && (y_w == '0);
    end
  end

  assign pix_o   = pix_q;
  assign hsync_o = hs_q;
  assign vsync_o = vs_q;
endmodule

// File: rtl/vid_bitmap_scan_chk.sv
module vid_bitmap_scan_chk #(
  parameter int H  = 64,
  parameter int V  = 48,
  parameter int YW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          wr_done_o,
  input logic          wr_req_i,
  input logic [YW-1:0] wr_y_i,
  input logic          clr_act_i,
  input logic          wr_pend_i
);
  localparam int HW = $clog2(H);
  localparam int FW = $clog2(H * V);

  logic [HW-1:0] hc_q;
  logic [FW-1:0] fc_q;
  logic          h_seen_q, v_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q <= '0; fc_q <= '0; h_seen_q <= 1'b0; v_seen_q <= 1'b0;
    end else begin
      hc_q <= hsync_o ? '0 : hc_q + 1'b1;
      fc_q <= vsync_o ? '0 : fc_q + 1'b1;
      if (hsync_o) h_seen_q <= 1'b1;
      if (vsync_o) v_seen_q <= 1'b1;
    end
  end

  AST_HSYNC_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_seen_q |-> (hsync_o == (hc_q == HW'(H - 1)))); // R2
  AST_VSYNC_ON_HSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> hsync_o); // R3
  AST_VSYNC_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_seen_q |-> (vsync_o == (fc_q == FW'(H * V - 1)))); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o); // R5
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pend_i && !wr_done_o) |=> (wr_pend_i || wr_done_o)); // R6
  AST_BAD_ROW_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pend_i && wr_req_i && (int'(wr_y_i) >= V)) |=> !wr_pend_i); // R7
  AST_NO_COMMIT_IN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_act_i |-> !wr_done_o); // R9
endmodule

bind vid_bitmap_scan vid_bitmap_scan_chk #(.H(H), .V(V), .YW(YW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .wr_done_o (wr_done_o),
  .wr_req_i  (wr_req_i),
  .wr_y_i    (wr_y_i),
  .clr_act_i (clr_act_w),
  .wr_pend_i (wr_pend_w)
);

// File: tb/test_vid_bitmap_scan.sv
`timescale 1ns/1ps
module test_vid_bitmap_scan;
  localparam int BW = 16, BH = 16;
  localparam int H = 4 * BW, V = 3 * BH;
  localparam int XW = $clog2(H), YW = $clog2(V);
  localparam int FRAME = H * V;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 1'b0, wr_val = 1'b0, clr_req = 1'b0, clr_fill = 1'b0;
  logic [XW-1:0] wr_x = '0;
  logic [YW-1:0] wr_y = '0;
  logic wr_done, pix, hs, vs;

  int  n_tests = 0, n_fail = 0, done_cnt = 0;
  bit  finished = 0;
  bit  img [FRAME];

  always #2.5 clk = ~clk;

  vid_bitmap_scan #(.BANK_W(BW), .BANK_H(BH)) i_vid_bitmap_scan (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .wr_x_i(wr_x),
    .wr_y_i(wr_y), .wr_val_i(wr_val), .wr_done_o(wr_done),
    .clr_req_i(clr_req), .clr_fill_i(clr_fill),
    .pix_o(pix), .hsync_o(hs), .vsync_o(vs)
  );

  always @(posedge clk) if (rst_n && wr_done) done_cnt <= done_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wait_vs();
    do @(negedge clk); while (!vs);
  endtask

  task automatic check_frame(input string req);
    int bad = 0, sbad = 0, fx = -1, fy = -1, fa = 0, fe = 0;
    wait_vs();
    for (int y = 0; y < V; y++) begin
      for (int x = 0; x < H; x++) begin
        if (x != 0 || y != 0) @(negedge clk);
        if (pix !== img[y*H+x]) begin
          if (bad == 0) begin fx = x; fy = y; fa = int'(pix); fe = int'(img[y*H+x]); end
          bad++;
        end
        if (hs !== (x == 0) || vs !== (x == 0 && y == 0)) sbad++;
      end
    end
    if (bad != 0) $display("  first pixel mismatch at x=%0d y=%0d", fx, fy);
    chk(bad == 0, req, "frame pixel", fa, fe);
    chk(sbad == 0, "R2 R3", "sync strobe mismatches", sbad, 0);
  endtask

  task automatic issue_write(input int x, input int y, input bit v);
    @(negedge clk);
    wr_req = 1'b1; wr_x = XW'(x); wr_y = YW'(y); wr_val = v;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!wr_done && cyc < FRAME + 64) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_write(input int x, input int y, input bit v, input string req);
    int c;
    issue_write(x, y, v);
    wait_done(c);
    chk(wr_done && c <= FRAME + 8, "R5", "write done latency", c, FRAME + 8);
    img[y*H+x] = v;
    @(negedge clk);
  endtask

  task automatic start_clear(input bit f);
    wait_vs();
    repeat (10) @(negedge clk);
    clr_req = 1'b1; clr_fill = f;
    @(negedge clk);
    clr_req = 1'b0;
    for (int i = 0; i < FRAME; i++) img[i] = f;
  endtask

  initial begin
    int d0, c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(pix == 1'b0 && hs == 1'b0 && vs == 1'b0, "R10", "video outputs in reset",
        int'({pix, hs, vs}), 0);
    chk(wr_done == 1'b0, "R10", "done in reset", int'(wr_done), 0);
    rst_n = 1'b1;

    start_clear(1'b0);
    check_frame("R8 black clear");

    // corners and bank edges (R4)
    do_write(0, 0, 1'b1, "R4");
    do_write(H-1, 0, 1'b1, "R4");
    do_write(0, V-1, 1'b1, "R4");
    do_write(H-1, V-1, 1'b1, "R4");
    do_write(3, BH-1, 1'b1, "R4");
    do_write(4, BH, 1'b1, "R4");
    do_write(BW*2+1, 2*BH, 1'b1, "R4");
    check_frame("R4 corners");

    // random pattern (R1 R4)
    for (int i = 0; i < 12; i++) begin
      int x = int'($urandom % H);
      int y = int'($urandom % V);
      do_write(x, y, bit'($urandom % 2), "R4");
    end
    check_frame("R1 R4 random");
    do_write(1, 1, !img[1*H+1], "R4");
    check_frame("R1 R4 overwrite");

    // second request while busy (R6)
    wait_vs();
    d0 = done_cnt;
    issue_write(7, V-1, !img[(V-1)*H+7]);
    issue_write(9, V-2, !img[(V-2)*H+9]);
    img[(V-1)*H+7] = !img[(V-1)*H+7];
    repeat (FRAME + 64) @(negedge clk);
    chk(done_cnt - d0 == 1, "R6", "done pulses for busy pair", done_cnt - d0, 1);
    check_frame("R6 busy drop");

    // out-of-range row (R7)
    d0 = done_cnt;
    issue_write(3, V + 3, 1'b1);
    repeat (FRAME + 64) @(negedge clk);
    chk(done_cnt == d0, "R7", "done for row beyond raster", done_cnt - d0, 0);
    do_write(11, 20, !img[20*H+11], "R7");
    check_frame("R7 later write");

    // clear wins over a pending write (R8 R9)
    start_clear(1'b1);
    d0 = done_cnt;
    issue_write(5, 3, 1'b0);
    check_frame("R8 white clear");
    chk(done_cnt == d0, "R9", "write committed during clear", done_cnt - d0, 0);
    wait_done(c);
    chk(wr_done == 1'b1, "R9", "held write committed", int'(wr_done), 1);
    img[3*H+5] = 1'b0;
    @(negedge clk);
    check_frame("R9 write over fill");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule